// File: doc/BRIEF.md
# Fully Associative Micro Translation Buffer

This block is a ten-entry, fully associative address translation buffer that sits in front of a level-1 cache. Every entry maps one virtual page to one physical page, and each entry has its own page size: 4KB, 64KB, 1MB or 16MB. The lookup address is compared against all valid entries at the same time. The translated physical address is registered and appears one clock after the request. On a hit, the offset bits below the page boundary are copied unchanged from the virtual address.

A lookup that finds no entry raises a miss request toward a larger backing translation buffer. That buffer later writes the answer back through the fill port, giving the virtual page, the physical page and the size code. When a fill arrives, the block chooses the slot to write in this order:

1. An entry whose region overlaps the new page.
2. The lowest-numbered free slot.
3. The replacement policy: a round-robin pointer, or a free-running pseudo-random generator, selected by an input.

A single strobe invalidates the whole table.

Top module: `utlb_fa`

## Requirements
- R1: While reset is high and after it is released, every entry is invalid and resp_valid, resp_hit and miss_req are 0.
- R2: A lookup requested with lk_valid in one cycle produces resp_valid one clock later. It sees the table as it stood before that clock edge, so a fill in the same cycle is not visible to it. Without lk_valid, resp_valid and miss_req stay 0.
- R3: The size code selects the page size and the number of offset bits: 0 = 4KB (12 bits), 1 = 64KB (16), 2 = 1MB (20), 3 = 16MB (24). Virtual address bits below the page boundary are ignored in the match and passed through to resp_pa. Physical page bits below the boundary are ignored.
- R4: A lookup that matches no valid entry returns resp_hit = 0 and resp_pa = 0. It raises miss_req for exactly one cycle, with miss_vpn equal to lk_va[31:12].
- R5: When no valid entry overlaps the fill, the fill goes to the lowest-numbered invalid slot, and no valid entry is lost.
- R6: When the table is full and repl_random is 0, victims are taken in slot order starting at slot 0 after reset, wrapping after slot 9. The pointer advances only when it chooses a victim.
- R7: When the table is full and repl_random is 1, exactly one existing entry is replaced. The victim is an 8-bit LFSR value, taken modulo 10.
- R8: A fill whose region overlaps valid entries (compared at the larger of the two sizes) overwrites the lowest overlapping entry and invalidates the others. Any address therefore hits at most one entry.
- R9: inv_all clears every valid bit in one cycle. A fill presented in the same cycle is discarded.
- R10: The table holds ten distinct pages at once, and all of them hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| fill_valid | input | 1 | Write a translation from the backing buffer |
| fill_vpn | input | 20 | Virtual page number of the fill (address bits 31:12) |
| fill_ppn | input | 20 | Physical page number of the fill (address bits 31:12) |
| fill_size | input | 2 | Page size code of the fill |
| repl_random | input | 1 | 1 selects pseudo-random victims, 0 selects round robin |
| inv_all | input | 1 | Invalidate every entry |
| resp_valid | output | 1 | Lookup result valid |
| resp_hit | output | 1 | Lookup found a translation |
| resp_pa | output | 32 | Translated physical address |
| miss_req | output | 1 | Request to the backing buffer |
| miss_vpn | output | 20 | Virtual page number that missed |

## Verification
The assertions assume that the table is only ever written through the fill port, so the single-hit property comes from the overlap handling and not from any promise about the stimulus. They also assume that all inputs are known once reset is released. The bench keeps to these assumptions by driving every input to a defined value from time zero and changing inputs only on the falling clock edge. It deliberately presents overlapping, duplicate and mixed-size fills so that the overlap path is exercised within those rules. The random-mode check relies only on the promise that exactly one old entry is lost, and it does not predict the victim slot.

// File: rtl/utlb_pkg.sv
package utlb_pkg;
  localparam int BASE_OFF = 12;
  localparam int SZ_W     = 2;
  localparam int SZ_STEP  = 4;

  typedef enum logic [SZ_W-1:0] {
    PG_4K  = 2'd0,
    PG_64K = 2'd1,
    PG_1M  = 2'd2,
    PG_16M = 2'd3
  } pg_size_e;
endpackage

// File: rtl/utlb_cam.sv
module utlb_cam
  import utlb_pkg::*;
#(
  parameter int ENTRIES = 10,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inv_all,
  input  logic [VPN_W-1:0]   look_vpn,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_slot,
  input  logic [ENTRIES-1:0] kill_mask,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [PPN_W-1:0]   fill_ppn,
  input  logic [SZ_W-1:0]    fill_size,
  output logic [ENTRIES-1:0] hit_vec,
  output logic [ENTRIES-1:0] ovl_vec,
  output logic [ENTRIES-1:0] valid_vec,
  output logic [PPN_W-1:0]   rd_ppn,
  output logic [SZ_W-1:0]    rd_size
);

  logic [VPN_W-1:0] ent_vpn  [ENTRIES];
  logic [PPN_W-1:0] ent_ppn  [ENTRIES];
  logic [SZ_W-1:0]  ent_size [ENTRIES];
  logic [ENTRIES-1:0] ent_vld;
  logic [VPN_W-1:0] fill_keep;

  // page-number bits that take part in a compare for a given size code
  function automatic logic [VPN_W-1:0] keep_bits(input logic [SZ_W-1:0] s);
    return ~((VPN_W'(1) << (SZ_STEP * int'(s))) - VPN_W'(1));
  endfunction

  assign fill_keep = keep_bits(fill_size);
  assign valid_vec = ent_vld;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_match
    logic [VPN_W-1:0] keep_i;
    assign keep_i     = keep_bits(ent_size[i]);
    assign hit_vec[i] = ent_vld[i] && (((look_vpn ^ ent_vpn[i]) & keep_i) == '0);
    // overlap is judged at the coarser of the two page sizes
    assign ovl_vec[i] = ent_vld[i] &&
                        (((fill_vpn ^ ent_vpn[i]) & keep_i & fill_keep) == '0);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (rst || inv_all) begin
        ent_vld[i] <= 1'b0;
      end else if (fill_en && (fill_slot == IDX_W'(i))) begin
        ent_vld[i]  <= 1'b1;
        ent_vpn[i]  <= fill_vpn;
        ent_ppn[i]  <= fill_ppn;
        ent_size[i] <= fill_size;
      end else if (fill_en && kill_mask[i]) begin
        ent_vld[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_ppn  = '0;
    rd_size = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) begin
        rd_ppn  = rd_ppn | ent_ppn[i];
        rd_size = rd_size | ent_size[i];
      end
    end
  end

  // R8: non-overlapping contents leave at most one matching entry
  a_r8_single_hit: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  // R9: a flush empties the table at the next edge
  a_r9_flush_clears: assert property (@(posedge clk) disable iff (rst)
    inv_all |=> (valid_vec == '0));

  // R5: a fill makes its target slot valid
  a_r5_fill_lands: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !inv_all) |=> (valid_vec != '0));

endmodule

// File: rtl/utlb_victim.sv
module utlb_victim #(
  parameter int ENTRIES   = 10,
  parameter int LFSR_W    = 8,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8,
  parameter int IDX_W     = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fill_en,
  input  logic               use_rand,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] ovl_vec,
  output logic [IDX_W-1:0]   slot,
  output logic [ENTRIES-1:0] kill_mask
);

  logic [LFSR_W-1:0] lfsr_q;
  logic [IDX_W-1:0]  rr_q;
  logic [IDX_W-1:0]  ovl_idx, free_idx, rand_idx;
  logic              has_ovl, has_free, take_ptr;

  // lowest overlapping slot and lowest free slot
  always_comb begin
    has_ovl  = 1'b0;
    ovl_idx  = '0;
    has_free = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (ovl_vec[i]) begin
        has_ovl = 1'b1;
        ovl_idx = IDX_W'(i);
      end
      if (!valid_vec[i]) begin
        has_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    kill_mask = '0;
    if (has_ovl) begin
      for (int i = 0; i < ENTRIES; i++) begin
        kill_mask[i] = ovl_vec[i] && (IDX_W'(i) != ovl_idx);
      end
    end
  end

  assign rand_idx = IDX_W'(lfsr_q % LFSR_W'(ENTRIES));
  assign take_ptr = fill_en && !has_ovl && !has_free && !use_rand;

  always_comb begin
    if (has_ovl)       slot = ovl_idx;
    else if (has_free) slot = free_idx;
    else if (use_rand) slot = rand_idx;
    else               slot = rr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr_q <= LFSR_W'(1);
      rr_q   <= '0;
    end else begin
      lfsr_q <= {lfsr_q[LFSR_W-2:0], ^(lfsr_q & LFSR_TAPS)};
      if (take_ptr) begin
        rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + IDX_W'(1);
      end
    end
  end

  // R6: the pointer never leaves the table
  a_r6_ptr_range: assert property (@(posedge clk) disable iff (rst)
    rr_q < IDX_W'(ENTRIES));

  // R6: a full-table round-robin fill moves the pointer
  a_r6_ptr_moves: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !use_rand && (&valid_vec) && (ovl_vec == '0)) |=> !$stable(rr_q));

  // R7: every chosen victim is a real slot
  a_r7_slot_range: assert property (@(posedge clk) disable iff (rst)
    fill_en |-> (slot < IDX_W'(ENTRIES)));

  // R7: random mode leaves the pointer alone
  a_r7_ptr_hold: assert property (@(posedge clk) disable iff (rst)
    use_rand |=> $stable(rr_q));

endmodule

// File: rtl/utlb_resp.sv
module utlb_resp
  import utlb_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int VPN_W = VA_W - BASE_OFF,
  parameter int PPN_W = PA_W - BASE_OFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_va,
  input  logic             any_hit,
  input  logic [PPN_W-1:0] rd_ppn,
  input  logic [SZ_W-1:0]  rd_size,
  output logic             resp_valid,
  output logic             resp_hit,
  output logic [PA_W-1:0]  resp_pa,
  output logic             miss_req,
  output logic [VPN_W-1:0] miss_vpn
);

  logic [PA_W-1:0] low_mask, va_ext, page_base, pa_next;
  int unsigned     off_bits;

  assign off_bits  = BASE_OFF + SZ_STEP * int'(rd_size);
  assign low_mask  = (PA_W'(1) << off_bits) - PA_W'(1);
  assign va_ext    = PA_W'(lk_va);
  assign page_base = {rd_ppn, {BASE_OFF{1'b0}}};
  assign pa_next   = (page_base & ~low_mask) | (va_ext & low_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_pa    <= '0;
      miss_req   <= 1'b0;
      miss_vpn   <= '0;
    end else begin
      resp_valid <= lk_valid;
      resp_hit   <= lk_valid && any_hit;
      resp_pa    <= (lk_valid && any_hit) ? pa_next : '0;
      miss_req   <= lk_valid && !any_hit;
      if (lk_valid && !any_hit) miss_vpn <= lk_va[VA_W-1:BASE_OFF];
    end
  end

  // R2: one response per request, one clock later
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> resp_valid);

  a_r2_idle: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> (!resp_valid && !miss_req));

  // R4: a miss request never accompanies a hit
  a_r4_miss_excl: assert property (@(posedge clk) disable iff (rst)
    miss_req |-> (resp_valid && !resp_hit));

endmodule

// File: rtl/utlb_fa.sv
module utlb_fa
  import utlb_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int ENTRIES = 10,
  parameter int LFSR_W  = 8,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     lk_valid,
  input  logic [VA_W-1:0]          lk_va,
  input  logic                     fill_valid,
  input  logic [VA_W-BASE_OFF-1:0] fill_vpn,
  input  logic [PA_W-BASE_OFF-1:0] fill_ppn,
  input  logic [SZ_W-1:0]          fill_size,
  input  logic                     repl_random,
  input  logic                     inv_all,
  output logic                     resp_valid,
  output logic                     resp_hit,
  output logic [PA_W-1:0]          resp_pa,
  output logic                     miss_req,
  output logic [VA_W-BASE_OFF-1:0] miss_vpn
);

  localparam int VPN_W = VA_W - BASE_OFF;
  localparam int PPN_W = PA_W - BASE_OFF;
  localparam int IDX_W = $clog2(ENTRIES);

  logic               fill_go;
  logic [ENTRIES-1:0] hit_vec, ovl_vec, valid_vec, kill_mask;
  logic [IDX_W-1:0]   slot;
  logic [PPN_W-1:0]   rd_ppn;
  logic [SZ_W-1:0]    rd_size;

  assign fill_go = fill_valid && !inv_all;

  utlb_cam #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)
  ) u_cam (
    .clk(clk), .rst(rst), .inv_all(inv_all),
    .look_vpn(lk_va[VA_W-1:BASE_OFF]),
    .fill_en(fill_go), .fill_slot(slot), .kill_mask(kill_mask),
    .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_size(fill_size),
    .hit_vec(hit_vec), .ovl_vec(ovl_vec), .valid_vec(valid_vec),
    .rd_ppn(rd_ppn), .rd_size(rd_size)
  );

  utlb_victim #(
    .ENTRIES(ENTRIES), .LFSR_W(LFSR_W), .LFSR_TAPS(LFSR_TAPS), .IDX_W(IDX_W)
  ) u_victim (
    .clk(clk), .rst(rst), .fill_en(fill_go), .use_rand(repl_random),
    .valid_vec(valid_vec), .ovl_vec(ovl_vec),
    .slot(slot), .kill_mask(kill_mask)
  );

  utlb_resp #(
    .VA_W(VA_W), .PA_W(PA_W), .VPN_W(VPN_W), .PPN_W(PPN_W)
  ) u_resp (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_va(lk_va),
    .any_hit(|hit_vec), .rd_ppn(rd_ppn), .rd_size(rd_size),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_pa(resp_pa),
    .miss_req(miss_req), .miss_vpn(miss_vpn)
  );

  // R1: nothing is reported in the first cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!resp_valid && !resp_hit && !miss_req));

endmodule

// File: tb/utlb_fa_test.sv
module utlb_fa_test;
  import utlb_pkg::*;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] va;
    logic        hit;
    logic [31:0] pa;
  } vec_t;

  // R3/R4: lookups against the four mixed-size pages filled below
  localparam vec_t VECS [10] = '{
    '{32'h00010ABC, 1'b1, 32'h80000ABC},
    '{32'h00011000, 1'b0, 32'h00000000},
    '{32'h0012FFFF, 1'b1, 32'h9003FFFF},
    '{32'h00123456, 1'b1, 32'h90033456},
    '{32'h00130000, 1'b0, 32'h00000000},
    '{32'h005ABCDE, 1'b1, 32'hA01ABCDE},
    '{32'h00600000, 1'b0, 32'h00000000},
    '{32'h03FEDCBA, 1'b1, 32'hB2FEDCBA},
    '{32'h04000000, 1'b0, 32'h00000000},
    '{32'h00000000, 1'b0, 32'h00000000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_va = '0;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_ppn = '0;
  logic [1:0]  fill_size = '0;
  logic        repl_random = 1'b0;
  logic        inv_all = 1'b0;
  logic        resp_valid, resp_hit, miss_req;
  logic [31:0] resp_pa;
  logic [19:0] miss_vpn;

  int checks = 0;
  int errors = 0;
  logic [31:0] cur_va [10];

  utlb_fa uut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_va(lk_va),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_size(fill_size), .repl_random(repl_random), .inv_all(inv_all),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_pa(resp_pa),
    .miss_req(miss_req), .miss_vpn(miss_vpn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] va);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_va    = va;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn,
                      input logic [1:0] sz);
    @(negedge clk);
    fill_valid = 1'b1;
    fill_vpn   = vpn;
    fill_ppn   = ppn;
    fill_size  = sz;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic expect_hit(input string req, input logic [31:0] va,
                            input logic [31:0] pa);
    lookup(va);
    chk(req, "resp_valid", 32'(resp_valid), 32'd1);
    chk(req, "resp_hit", 32'(resp_hit), 32'd1);
    chk(req, "resp_pa", resp_pa, pa);
  endtask

  task automatic expect_miss(input string req, input logic [31:0] va);
    lookup(va);
    chk(req, "resp_hit", 32'(resp_hit), 32'd0);
    chk(req, "miss_req", 32'(miss_req), 32'd1);
    chk(req, "miss_vpn", 32'(miss_vpn), 32'(va[31:12]));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hits;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: quiet outputs under reset
    chk("R1", "resp_valid in reset", 32'(resp_valid), 32'd0);
    chk("R1", "miss_req in reset", 32'(miss_req), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "resp_hit after reset", 32'(resp_hit), 32'd0);
    expect_miss("R1", 32'h00010ABC);
    @(negedge clk);
    // R2/R4: no request, no response; miss pulse lasted one cycle
    chk("R2", "resp_valid idle", 32'(resp_valid), 32'd0);
    chk("R4", "miss_req one cycle", 32'(miss_req), 32'd0);

    // R2: a fill in the same cycle as a lookup is not seen by it
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = 20'h00010; fill_ppn = 20'h80000; fill_size = PG_4K;
    lk_valid = 1'b1; lk_va = 32'h00010ABC;
    @(negedge clk);
    fill_valid = 1'b0; lk_valid = 1'b0;
    chk("R2", "same-cycle fill hidden", 32'(resp_hit), 32'd0);
    chk("R2", "resp_valid", 32'(resp_valid), 32'd1);

    fill(20'h00120, 20'h90037, PG_64K);
    fill(20'h00500, 20'hA0123, PG_1M);
    fill(20'h03000, 20'hB2345, PG_16M);

    // R3/R4: vector walk
    foreach (VECS[k]) begin
      if (VECS[k].hit) expect_hit("R3", VECS[k].va, VECS[k].pa);
      else             expect_miss("R4", VECS[k].va);
    end

    // R9: flush with a simultaneous fill
    @(negedge clk);
    inv_all = 1'b1; fill_valid = 1'b1;
    fill_vpn = 20'h06000; fill_ppn = 20'h12345; fill_size = PG_4K;
    @(negedge clk);
    inv_all = 1'b0; fill_valid = 1'b0;
    expect_miss("R9", 32'h00010ABC);
    expect_miss("R9", 32'h03FEDCBA);
    expect_miss("R9", 32'h06000000);

    // R8: overlapping fill merges two small pages into one large one
    fill(20'h07001, 20'h11111, PG_4K);
    fill(20'h07005, 20'h22222, PG_4K);
    fill(20'h09000, 20'h33333, PG_4K);
    fill(20'h07000, 20'hC0000, PG_16M);
    expect_hit("R8", 32'h07001234, 32'hC0001234);
    expect_hit("R8", 32'h07005000, 32'hC0005000);
    expect_hit("R8", 32'h09000010, 32'h33333010);
    fill(20'h09000, 20'hD0000, PG_4K);
    expect_hit("R8", 32'h09000010, 32'hD0000010);

    // R5/R10: freed slot and remaining slots fill without eviction
    for (int k = 0; k < 8; k++) fill(20'h10000 + 20'(k), 20'h20000 + 20'(k), PG_4K);
    expect_hit("R10", 32'h07001234, 32'hC0001234);
    expect_hit("R10", 32'h09000010, 32'hD0000010);
    for (int k = 0; k < 8; k++)
      expect_hit("R5", {20'h10000 + 20'(k), 12'h034}, {20'h20000 + 20'(k), 12'h034});

    // R6: round robin starts at slot 0 (large page), then slot 1 (first small)
    fill(20'h30000, 20'h40000, PG_4K);
    expect_miss("R6", 32'h07001234);
    expect_hit("R6", 32'h30000008, 32'h40000008);
    fill(20'h30001, 20'h40001, PG_4K);
    expect_miss("R6", 32'h10000034);
    expect_hit("R6", 32'h10001034, 32'h20001034);
    expect_hit("R6", 32'h30001008, 32'h40001008);

    // R7: random mode evicts exactly one resident page
    cur_va[0] = 32'h30000008;
    cur_va[1] = 32'h30001008;
    cur_va[2] = 32'h09000010;
    for (int k = 1; k < 8; k++) cur_va[k+2] = {20'h10000 + 20'(k), 12'h034};
    repl_random = 1'b1;
    fill(20'h50000, 20'h60000, PG_4K);
    repl_random = 1'b0;
    hits = 0;
    for (int k = 0; k < 10; k++) begin
      lookup(cur_va[k]);
      if (resp_hit) hits++;
    end
    chk("R7", "survivors", 32'(hits), 32'd9);
    expect_hit("R7", 32'h50000ABC, 32'h60000ABC);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule